// File: doc/BRIEF.md
# Peripheral Power State Controller

This block sits between a central power and sleep master and one peripheral. The master asks for one of three operating states: enabled, idle, or synchronized reset. The controller turns each request into an ordered sequence on three plain control outputs. These are a clock enable for the peripheral, an active-high peripheral reset, and a permit that allows register access. The controller also reports which state it is in, or that it is between states.

A small bank of registers stands in for the peripheral's internal state. Idle stops the clock and keeps the bank intact. Synchronized reset first holds reset with the clock still running, so the bank returns to its defaults, and only then stops the clock. Leaving synchronized reset reverses that order. Software must then reinitialize the bank.

A host reaches the bank through a request channel with valid/ready handshaking. `acc_ready_o` is always high, so the host never sees back-pressure: every cycle with `acc_valid_i` high is one accepted request. Exactly one response follows, one cycle later. The response channel has no ready input, so the host must take each response in the cycle it is offered.

Top module: `pwr_state_ctl`

## Requirements
- R1: While idle, `clk_en_o` is 0, `periph_rst_o` is 0, `access_ok_o` is 0, and `pwr_state_o` reads 2'b01.
- R2: An access accepted in any state other than enabled gets a response with `rsp_err_o`=1 and `rsp_rdata_o`=0. A refused write changes no register.
- R3: After a round trip through idle, every register reads back the value it held before idle was entered.
- R4: On a synchronized-reset request, `periph_rst_o` rises while `clk_en_o` stays 1 for exactly HOLD_CYC (default 2) cycles. During those cycles `pwr_state_o` reads 2'b11. Then `clk_en_o` drops, and `pwr_state_o` reads 2'b10 while the block stays in synchronized reset.
- R5: After synchronized reset, register i reads DEF_BASE + i (default 16'hC3A0 + i), whatever was written before.
- R6: A request to enable, made from synchronized reset, raises `clk_en_o` first. Reset stays high for WAKE_CYC (default 2) further cycles, with `pwr_state_o` reading 2'b11. Then reset falls and the state reads 2'b00.
- R7: Request encoding on `pwr_req_i` is 2'b00 enable, 2'b01 idle, 2'b10 synchronized reset, and 2'b11 keep the current state. An idle request made during synchronized reset is ignored.
- R8: Enabled (state 2'b00, clock on, reset low, permit high) accepts every access, with `acc_ready_o` always 1. The response comes on the next cycle with `rsp_err_o`=0. A read returns the register contents and a write returns zero data.
- R9: After power-on reset (`rst_n` low), the block is enabled and every register holds its default.
- R10: Requests that arrive during a reset-entry or wake-up sequence are ignored until that sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pwr_req_i | input | 2 | Requested state (encoding in R7) |
| pwr_state_o | output | 2 | Reported state: 00 enabled, 01 idle, 10 sync reset, 11 moving |
| clk_en_o | output | 1 | Peripheral clock enable |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| access_ok_o | output | 1 | Register access permitted |
| acc_valid_i | input | 1 | Host access request valid |
| acc_ready_o | output | 1 | Host access accepted (always 1) |
| acc_write_i | input | 1 | 1 write, 0 read |
| acc_addr_i | input | AW | Register index |
| acc_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_err_o | output | 1 | Access refused |
| rsp_rdata_o | output | DW | Read data, zero on refusal or write |

## Verification
The bench goes after the orderings first. It counts the cycles in which reset overlaps the running clock, on entry to and exit from synchronized reset. A design that gated the clock in the same cycle as reset would never clear the bank, and reads after wake-up would return stale data instead of defaults. Writes attempted during idle are followed by read-back after wake-up, so a design that let a refused write through, or lost contents while gated, is caught. The bench also sends requests during a sequence, and idle requests during synchronized reset. A design that obeyed these would either cut the reset hold short or report a state the encoding forbids.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [1:0] {
    REQ_ON   = 2'b00,
    REQ_IDLE = 2'b01,
    REQ_SRST = 2'b10,
    REQ_KEEP = 2'b11
  } pwr_req_e;

  typedef enum logic [1:0] {
    CODE_ON     = 2'b00,
    CODE_IDLE   = 2'b01,
    CODE_SRST   = 2'b10,
    CODE_MOVING = 2'b11
  } pwr_code_e;

  typedef enum logic [2:0] {
    PH_ON,
    PH_IDLE,
    PH_HOLD,
    PH_SRST,
    PH_WAKE
  } pwr_phase_e;

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_state_pkg::*;
#(
  parameter int HOLD_CYC = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  output logic [1:0] code_o,
  output logic       clk_en_o,
  output logic       prst_o,
  output logic       permit_o
);

  localparam int MAXC = (HOLD_CYC > WAKE_CYC) ? HOLD_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);

  pwr_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  pwr_req_e req;

  assign req = pwr_req_e'(req_i);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = '0;
    unique case (phase_q)
      PH_ON: begin
        if (req == REQ_IDLE)      phase_d = PH_IDLE;
        else if (req == REQ_SRST) phase_d = PH_HOLD;
      end
      PH_IDLE: begin
        if (req == REQ_ON)        phase_d = PH_ON;
        else if (req == REQ_SRST) phase_d = PH_HOLD;
      end
      PH_HOLD: begin
        if (cnt_q == HOLD_LAST) phase_d = PH_SRST;
        else                    cnt_d = cnt_q + 1'b1;
      end
      PH_SRST: begin
        if (req == REQ_ON) phase_d = PH_WAKE;
      end
      PH_WAKE: begin
        if (cnt_q == WAKE_LAST) phase_d = PH_ON;
        else                    cnt_d = cnt_q + 1'b1;
      end
      default: phase_d = PH_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ON;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    clk_en_o = 1'b0;
    prst_o   = 1'b0;
    permit_o = 1'b0;
    code_o   = CODE_MOVING;
    unique case (phase_q)
      PH_ON:   begin clk_en_o = 1'b1; permit_o = 1'b1; code_o = CODE_ON; end
      PH_IDLE: begin code_o = CODE_IDLE; end
      PH_HOLD: begin clk_en_o = 1'b1; prst_o = 1'b1; end
      PH_SRST: begin prst_o = 1'b1; code_o = CODE_SRST; end
      PH_WAKE: begin clk_en_o = 1'b1; prst_o = 1'b1; end
      default: begin code_o = CODE_MOVING; end
    endcase
  end

  AST_RST_LEADS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_o && $past(clk_en_o) && prst_o) |-> ($past(prst_o) && $past(prst_o, 2))); // R4

  AST_CLK_LEADS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prst_o) |-> (clk_en_o && $past(clk_en_o) && $past(clk_en_o, 2))); // R6

  AST_IDLE_IN_SRST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SRST && req == REQ_IDLE) |=> (code_o == CODE_SRST)); // R7

  AST_SEQ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD && cnt_q != HOLD_LAST) |=> (phase_q == PH_HOLD)); // R10

endmodule

// File: rtl/pwr_reg_bank.sv
module pwr_reg_bank #(
  parameter int          NREGS    = 4,
  parameter int          DW       = 16,
  parameter int unsigned DEF_BASE = 32'hC3A0,
  localparam int         AW       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_i,
  input  logic                      prst_i,
  input  logic                      we_i,
  input  logic [AW-1:0]             waddr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NREGS-1:0][DW-1:0]  regs_o
);

  logic [NREGS-1:0][DW-1:0] defaults;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [DW-1:0] DEF = DW'(DEF_BASE + g);
    assign defaults[g] = DEF;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[g] <= DEF;
      end else if (clk_en_i) begin
        if (prst_i)                                 regs_o[g] <= DEF;
        else if (we_i && waddr_i == AW'(g))         regs_o[g] <= wdata_i;
      end
    end
  end

  AST_HOLD_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> $stable(regs_o)); // R3

  AST_DEFAULTS_AFTER_PRST: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_i && prst_i) |=> (regs_o == defaults)); // R5

endmodule

// File: rtl/pwr_access_port.sv
module pwr_access_port #(
  parameter int  NREGS = 4,
  parameter int  DW    = 16,
  localparam int AW    = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     permit_i,
  input  logic                     acc_valid_i,
  output logic                     acc_ready_o,
  input  logic                     acc_write_i,
  input  logic [AW-1:0]            acc_addr_i,
  input  logic [DW-1:0]            acc_wdata_i,
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  output logic                     we_o,
  output logic [AW-1:0]            waddr_o,
  output logic [DW-1:0]            wdata_o,
  output logic                     rsp_valid_o,
  output logic                     rsp_err_o,
  output logic [DW-1:0]            rsp_rdata_o
);

  assign acc_ready_o = 1'b1;
  assign we_o        = acc_valid_i && acc_write_i && permit_i;
  assign waddr_o     = acc_addr_i;
  assign wdata_o     = acc_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= acc_valid_i;
      rsp_err_o   <= acc_valid_i && !permit_i;
      if (acc_valid_i && permit_i && !acc_write_i) rsp_rdata_o <= regs_i[acc_addr_i];
      else                                         rsp_rdata_o <= '0;
    end
  end

  AST_REFUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == '0)); // R2

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> rsp_valid_o); // R8

  AST_DENIED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !permit_i) |=> rsp_err_o); // R2

endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl #(
  parameter int          NREGS    = 4,
  parameter int          DW       = 16,
  parameter int unsigned DEF_BASE = 32'hC3A0,
  parameter int          HOLD_CYC = 2,
  parameter int          WAKE_CYC = 2,
  localparam int         AW       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pwr_req_i,
  output logic [1:0]    pwr_state_o,
  output logic          clk_en_o,
  output logic          periph_rst_o,
  output logic          access_ok_o,
  input  logic          acc_valid_i,
  output logic          acc_ready_o,
  input  logic          acc_write_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o
);

  logic                     we;
  logic [AW-1:0]            waddr;
  logic [DW-1:0]            wdata;
  logic [NREGS-1:0][DW-1:0] regs;

  pwr_seq_fsm #(
    .HOLD_CYC (HOLD_CYC),
    .WAKE_CYC (WAKE_CYC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (pwr_req_i),
    .code_o   (pwr_state_o),
    .clk_en_o (clk_en_o),
    .prst_o   (periph_rst_o),
    .permit_o (access_ok_o)
  );

  pwr_reg_bank #(
    .NREGS    (NREGS),
    .DW       (DW),
    .DEF_BASE (DEF_BASE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_i (clk_en_o),
    .prst_i   (periph_rst_o),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .regs_o   (regs)
  );

  pwr_access_port #(
    .NREGS (NREGS),
    .DW    (DW)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .permit_i    (access_ok_o),
    .acc_valid_i (acc_valid_i),
    .acc_ready_o (acc_ready_o),
    .acc_write_i (acc_write_i),
    .acc_addr_i  (acc_addr_i),
    .acc_wdata_i (acc_wdata_i),
    .regs_i      (regs),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  AST_GATED_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'b01) |-> (!clk_en_o && !periph_rst_o && !access_ok_o)); // R1

endmodule

// File: tb/pwr_state_ctl_bench.sv
module pwr_state_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 4;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam logic [15:0] DEF_BASE = 16'hC3A0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pwr_req_i = 2'b11;
  logic [1:0]    pwr_state_o;
  logic          clk_en_o, periph_rst_o, access_ok_o;
  logic          acc_valid_i = 1'b0;
  logic          acc_ready_o;
  logic          acc_write_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic [DW-1:0] acc_wdata_i = '0;
  logic          rsp_valid_o, rsp_err_o;
  logic [DW-1:0] rsp_rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctl u_pwr_state_ctl (
    .clk(clk), .rst_n(rst_n), .pwr_req_i(pwr_req_i), .pwr_state_o(pwr_state_o),
    .clk_en_o(clk_en_o), .periph_rst_o(periph_rst_o), .access_ok_o(access_ok_o),
    .acc_valid_i(acc_valid_i), .acc_ready_o(acc_ready_o), .acc_write_i(acc_write_i),
    .acc_addr_i(acc_addr_i), .acc_wdata_i(acc_wdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model: 0 on, 1 idle, 2 reset hold, 3 sync reset, 4 wake
  int          m_st, m_cnt;
  logic [15:0] m_reg [NREGS];
  bit          m_clean [NREGS];
  bit          m_rv, m_re;
  logic [15:0] m_rd;
  string       m_rtag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_code(int st);
    case (st)
      0: return 2'b00;
      1: return 2'b01;
      3: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic string st_tag(int st);
    case (st)
      0: return "R7";
      1: return "R1";
      2: return "R4";
      3: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_rv = 0; m_re = 0; m_rd = '0; m_rtag = "R9";
    for (int i = 0; i < NREGS; i++) begin
      m_reg[i] = DEF_BASE + 16'(i);
      m_clean[i] = 1;
    end
  endtask

  task automatic model_update(logic [1:0] rq, bit v, bit w, int a, logic [15:0] d);
    m_rv = v; m_re = 0; m_rd = '0;
    if (v) begin
      if (m_st != 0) begin
        m_re = 1; m_rtag = "R2";
      end else if (w) begin
        m_reg[a] = d; m_clean[a] = 0; m_rtag = "R8";
      end else begin
        m_rd = m_reg[a];
        m_rtag = m_clean[a] ? "R5" : "R3";
      end
    end
    if (m_st == 2 || m_st == 4) begin
      for (int i = 0; i < NREGS; i++) begin
        m_reg[i] = DEF_BASE + 16'(i);
        m_clean[i] = 1;
      end
    end
    case (m_st)
      0: if (rq == 2'b01) m_st = 1; else if (rq == 2'b10) begin m_st = 2; m_cnt = 0; end
      1: if (rq == 2'b00) m_st = 0; else if (rq == 2'b10) begin m_st = 2; m_cnt = 0; end
      2: if (m_cnt == 1) m_st = 3; else m_cnt++;
      3: if (rq == 2'b00) begin m_st = 4; m_cnt = 0; end
      default: if (m_cnt == 1) m_st = 0; else m_cnt++;
    endcase
  endtask

  task automatic check_outputs();
    string t;
    t = st_tag(m_st);
    chk(t, 32'(pwr_state_o), 32'(exp_code(m_st)));
    chk(t, 32'(clk_en_o), 32'(m_st == 0 || m_st == 2 || m_st == 4));
    chk(t, 32'(periph_rst_o), 32'(m_st >= 2));
    chk(t, 32'(access_ok_o), 32'(m_st == 0));
    chk("R8", 32'(acc_ready_o), 32'd1);
    chk("R8", 32'(rsp_valid_o), 32'(m_rv));
    if (m_rv) begin
      chk(m_rtag, 32'(rsp_err_o), 32'(m_re));
      chk(m_rtag, 32'(rsp_rdata_o), 32'(m_rd));
    end
  endtask

  task automatic step(logic [1:0] rq, bit v, bit w, int a, logic [15:0] d);
    pwr_req_i = rq; acc_valid_i = v; acc_write_i = w;
    acc_addr_i = AW'(a); acc_wdata_i = d;
    @(posedge clk);
    model_update(rq, v, w, a, d);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle_cycle(logic [1:0] rq);
    step(rq, 0, 0, 0, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: power-on state
    chk("R9", 32'(pwr_state_o), 32'h0);
    chk("R9", 32'(clk_en_o), 32'h1);
    chk("R9", 32'(periph_rst_o), 32'h0);
    for (int i = 0; i < NREGS; i++) step(2'b11, 1, 0, i, 16'h0);   // R9 defaults
    // R8: write then read every register
    for (int i = 0; i < NREGS; i++) step(2'b11, 1, 1, i, 16'h1110 * 16'(i + 1));
    for (int i = 0; i < NREGS; i++) step(2'b11, 1, 0, i, 16'h0);
    // R1/R2: idle, refused writes
    idle_cycle(2'b01);
    chk("R1", 32'(clk_en_o), 32'h0);
    step(2'b11, 1, 1, 0, 16'hDEAD);
    step(2'b11, 1, 0, 1, 16'h0);
    idle_cycle(2'b00);
    // R3: retention after idle
    for (int i = 0; i < NREGS; i++) step(2'b11, 1, 0, i, 16'h0);
    // R4/R10: sync reset entry, with requests during hold
    idle_cycle(2'b10);
    chk("R4", 32'({clk_en_o, periph_rst_o}), 32'h3);
    idle_cycle(2'b00);
    chk("R10", 32'(pwr_state_o), 32'h3);
    idle_cycle(2'b01);
    chk("R4", 32'({clk_en_o, periph_rst_o}), 32'h1);
    // R7: idle request ignored in sync reset
    idle_cycle(2'b01);
    chk("R7", 32'(pwr_state_o), 32'h2);
    step(2'b11, 1, 1, 2, 16'hBEEF);
    // R6: wake order
    idle_cycle(2'b00);
    chk("R6", 32'({clk_en_o, periph_rst_o}), 32'h3);
    idle_cycle(2'b10);
    chk("R10", 32'(pwr_state_o), 32'h3);
    idle_cycle(2'b11);
    chk("R6", 32'({clk_en_o, periph_rst_o}), 32'h2);
    // R5: defaults after sync reset
    for (int i = 0; i < NREGS; i++) step(2'b11, 1, 0, i, 16'h0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] rq;
      r = int'($urandom_range(0, 99));
      rq = (r < 4) ? 2'b00 : (r < 7) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      step(rq, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, NREGS - 1)), 16'($urandom));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule